// File: doc/BRIEF.md
# EDO DRAM Device-Side Bus Model

This block stands in for the memory end of an extended-data-out DRAM bus. A DRAM controller under test drives its usual multiplexed pins into it: the row strobe, one column strobe per byte lane, write enable, output enable, a 10-bit address and the write data. The model runs on a fast system clock and oversamples every pin through one register stage. It turns strobe edges into row and column latches, byte-lane writes and reads of a small internal array.

Real tri-state pins are not modelled. Each byte lane instead reports a drive flag, a data-valid flag and the read byte, and the data is zero whenever the lane is not driving. The array keeps only the low `ROW_BITS` of the row and the low `COL_BITS` of the column, so that a bench of any size stays small. Read latency is counted in sample clocks and set by `RD_LAT`. The model handles both early writes and delayed writes. It also models EDO output hold, where a lane keeps driving after its column strobe rises.

Top module: `edo_dram_model`

## Requirements
- R1: The row is taken from `addr` on a sampled falling edge of `ras_n`. The column is taken from `addr` on the first sampled falling edge of either `cas_n` bit, and later changes of `addr` do not move the access.
- R2: A second column strobe that falls before both `cas_n` bits have been sampled high reuses the column already latched. Once both bits have been seen high, the next fall latches a new column.
- R3: A byte lane whose `cas_n` bit falls while `we_n` is low (early write) stores its byte of `dq_in` at that edge. Bit 0 of `cas_n` owns `dq_in[7:0]` and bit 1 owns `dq_in[15:8]`. A lane whose strobe stays high keeps its stored byte.
- R4: After an early write, `dq_oe` stays 0 on both lanes until both column strobes are high again, even with `oe_n` low.
- R5: If `we_n` falls while a lane's `cas_n` bit is already low (delayed write), that lane stores the `dq_in` byte present at the `we_n` fall. Later changes of `dq_in` are not stored.
- R6: A lane drives (`dq_oe` bit 1) only after a read access has started on its own column strobe and while `oe_n` is low. Each lane follows its own strobe.
- R7: When a reading lane's column strobe rises, the lane keeps driving the same byte, with `we_n` high, `ras_n` low and `oe_n` low.
- R8: If `we_n` falls while both column strobes are high, all lanes stop driving.
- R9: During reset and whenever `ras_n` is sampled high, `dq_oe` and `dq_valid` are 0 and `dq_out` is 0. A rising `ras_n` also re-arms the column latch, even if a column strobe is still low.
- R10: A lane's `dq_valid` bit rises on the (`RD_LAT`+2)-th rising clock edge after its strobe fall: one edge samples the pin, one starts the access and `RD_LAT` edges count down. Before that the lane may drive but reports invalid.
- R11: Only the low `ROW_BITS` row bits and low `COL_BITS` column bits select a word. Addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, much faster than the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobes, one per byte lane, active low |
| we_n | input | 1 | Write enable, low selects write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 8*LANES | Write data from the controller |
| dq_out | output | 8*LANES | Read data, zero on lanes not driving |
| dq_oe | output | LANES | Per-lane drive flag replacing the tri-state |
| dq_valid | output | LANES | Per-lane flag for data past the access latency |

## Verification
The bench goes after the strobe orderings that controllers get wrong. A second column strobe without a precharge in between must reuse the old column; a model that latches again would return the other word. A write-enable fall with a strobe already low must store the data of that instant, not the data present when the strobe fell. A column strobe held low across a row-strobe rise must not block the next column latch. The bench also checks EDO hold after the strobe rises, the turn-off when write enable falls between strobes, and the exact cycle at which the valid flag rises. A design off by one cycle in the latency count, or one that drops the lanes to high impedance on the strobe rise, would fail these checks.

// File: rtl/edo_pkg.sv
package edo_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/edo_bus_sampler.sv
module edo_bus_sampler #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 2,
   localparam int DQ_W  = LANES * edo_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [LANES-1:0]  cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   din,
   output logic              s_ras_n,
   output logic [LANES-1:0]  s_cas_n,
   output logic              s_we_n,
   output logic              s_oe_n,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DQ_W-1:0]   s_din,
   output logic              ras_fall,
   output logic [LANES-1:0]  cas_fall,
   output logic              we_fall
);
   logic             p_ras_n;
   logic [LANES-1:0] p_cas_n;
   logic             p_we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_ras_n <= 1'b1;
         s_cas_n <= '1;
         s_we_n  <= 1'b1;
         s_oe_n  <= 1'b1;
         s_addr  <= '0;
         s_din   <= '0;
         p_ras_n <= 1'b1;
         p_cas_n <= '1;
         p_we_n  <= 1'b1;
      end else begin
         s_ras_n <= ras_n;
         s_cas_n <= cas_n;
         s_we_n  <= we_n;
         s_oe_n  <= oe_n;
         s_addr  <= addr;
         s_din   <= din;
         p_ras_n <= s_ras_n;
         p_cas_n <= s_cas_n;
         p_we_n  <= s_we_n;
      end
   end

   assign ras_fall = p_ras_n & ~s_ras_n;
   assign cas_fall = p_cas_n & ~s_cas_n;
   assign we_fall  = p_we_n & ~s_we_n;
endmodule

// File: rtl/edo_col_latch.sv
module edo_col_latch #(
   parameter int ADDR_W   = 10,
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int LANES    = 2,
   localparam int IDX_W   = ROW_BITS + COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_ras_n,
   input  logic [LANES-1:0]  s_cas_n,
   input  logic              s_we_n,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic              ras_fall,
   input  logic [LANES-1:0]  cas_fall,
   output logic [IDX_W-1:0]  word_idx,
   output logic              early_blk
);
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   logic                col_armed;
   logic                any_fall;
   logic                all_high;
   logic [COL_BITS-1:0] col_eff;

   assign any_fall = |cas_fall;
   assign all_high = &s_cas_n;
   assign col_eff  = col_armed ? s_addr[COL_BITS-1:0] : col_q;
   assign word_idx = {row_q, col_eff};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q     <= '0;
         col_q     <= '0;
         col_armed <= 1'b1;
         early_blk <= 1'b0;
      end else begin
         if (ras_fall) row_q <= s_addr[ROW_BITS-1:0];
         if (s_ras_n) begin
            col_armed <= 1'b1;
            early_blk <= 1'b0;
         end else begin
            if (any_fall && col_armed) begin
               col_q     <= s_addr[COL_BITS-1:0];
               col_armed <= 1'b0;
            end else if (all_high) begin
               col_armed <= 1'b1;
            end
            if (any_fall && !s_we_n) early_blk <= 1'b1;
            else if (all_high)       early_blk <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/edo_lane.sv
module edo_lane #(
   parameter int IDX_W  = 6,
   parameter int RD_LAT = 4,
   localparam int DEPTH = 1 << IDX_W,
   localparam int CNT_W = $clog2(RD_LAT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    word_idx,
   input  logic                s_ras_n,
   input  logic                cas_low,
   input  logic                cas_fall,
   input  logic                we_fall,
   input  logic                s_we_n,
   input  logic                s_oe_n,
   input  logic                early_blk,
   input  edo_pkg::byte_t      din,
   output edo_pkg::byte_t      dout,
   output logic                drive,
   output logic                valid
);
   edo_pkg::byte_t mem [DEPTH];
   edo_pkg::byte_t rd_byte;
   logic           rd_act;
   logic [CNT_W-1:0] lat_cnt;
   logic           early_wr, late_wr, rd_start;

   assign early_wr = !s_ras_n && cas_fall && !s_we_n;
   assign late_wr  = !s_ras_n && we_fall && cas_low && !cas_fall;
   assign rd_start = !s_ras_n && cas_fall && s_we_n;

   always_ff @(posedge clk) begin
      if (early_wr || late_wr) mem[word_idx] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_act  <= 1'b0;
         rd_byte <= '0;
         lat_cnt <= '0;
      end else begin
         if (s_ras_n) begin
            rd_act <= 1'b0;
         end else if (cas_fall) begin
            rd_act <= s_we_n;
         end else if (we_fall) begin
            rd_act <= 1'b0;
         end
         if (rd_start) begin
            rd_byte <= mem[word_idx];
            lat_cnt <= CNT_W'(RD_LAT);
         end else if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt - 1'b1;
         end
      end
   end

   assign drive = rd_act && !early_blk && !s_oe_n;
   assign valid = drive && (lat_cnt == '0);
   assign dout  = drive ? rd_byte : '0;
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
   parameter int ADDR_W   = 10,
   parameter int LANES    = 2,
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int RD_LAT   = 4,
   localparam int DQ_W    = LANES * edo_pkg::BYTE_W,
   localparam int IDX_W   = ROW_BITS + COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [LANES-1:0]  cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic [LANES-1:0]  dq_oe,
   output logic [LANES-1:0]  dq_valid
);
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if (ROW_BITS < 1 || ROW_BITS > ADDR_W || COL_BITS < 1 || COL_BITS > ADDR_W) begin : g_bad_bits
      $error("ROW_BITS and COL_BITS must lie in 1..ADDR_W");
   end
   if (IDX_W > 12) begin : g_bad_depth
      $error("array index wider than 12 bits");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic              s_ras_n, s_we_n, s_oe_n, ras_fall, we_fall;
   logic [LANES-1:0]  s_cas_n, cas_fall;
   logic [ADDR_W-1:0] s_addr;
   logic [DQ_W-1:0]   s_din;
   logic [IDX_W-1:0]  word_idx;
   logic              early_blk;

   edo_bus_sampler #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .din(dq_in), .s_ras_n(s_ras_n),
      .s_cas_n(s_cas_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n), .s_addr(s_addr),
      .s_din(s_din), .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall)
   );

   edo_col_latch #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
                   .LANES(LANES)) u_col (
      .clk(clk), .rst_n(rst_n), .s_ras_n(s_ras_n), .s_cas_n(s_cas_n),
      .s_we_n(s_we_n), .s_addr(s_addr), .ras_fall(ras_fall),
      .cas_fall(cas_fall), .word_idx(word_idx), .early_blk(early_blk)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      edo_lane #(.IDX_W(IDX_W), .RD_LAT(RD_LAT)) u_lane (
         .clk(clk), .rst_n(rst_n), .word_idx(word_idx), .s_ras_n(s_ras_n),
         .cas_low(!s_cas_n[g]), .cas_fall(cas_fall[g]), .we_fall(we_fall),
         .s_we_n(s_we_n), .s_oe_n(s_oe_n), .early_blk(early_blk),
         .din(s_din[g*edo_pkg::BYTE_W +: edo_pkg::BYTE_W]),
         .dout(dq_out[g*edo_pkg::BYTE_W +: edo_pkg::BYTE_W]),
         .drive(dq_oe[g]), .valid(dq_valid[g])
      );
   end
endmodule

// File: rtl/edo_dram_checker.sv
module edo_dram_checker #(
   parameter int LANES = 2,
   localparam int DQ_W = LANES * 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s_ras_n,
   input logic [LANES-1:0] s_cas_n,
   input logic             s_we_n,
   input logic             s_oe_n,
   input logic [LANES-1:0] cas_fall,
   input logic             we_fall,
   input logic [DQ_W-1:0]  dq_out,
   input logic [LANES-1:0] dq_oe,
   input logic [LANES-1:0] dq_valid
);
   // R9: a row strobe seen high leaves every lane silent
   assert_ras_high_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_ras_n) |-> (dq_oe == '0 && dq_valid == '0 && dq_out == '0));

   // R8: write enable falling between strobes turns the lanes off
   assert_we_fall_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_fall && (&s_cas_n) && !s_ras_n) |-> dq_oe == '0);

   for (genvar g = 0; g < LANES; g++) begin : g_chk
      // R4: an early write blocks the outputs
      assert_early_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cas_fall[g] && !s_we_n && !s_ras_n) |-> dq_oe == '0);

      // R10: a freshly started access is not yet valid
      assert_fresh_read_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cas_fall[g] && !s_ras_n) |-> !dq_valid[g]);

      // R7: EDO hold keeps the lane driving the same byte after its strobe rises
      assert_edo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(s_cas_n[g] && !$past(s_cas_n[g]) && dq_oe[g] && s_we_n && !s_ras_n)
          && !s_oe_n)
         |-> (dq_oe[g] && $stable(dq_out[g*8 +: 8])));
   end
endmodule

bind edo_dram_model edo_dram_checker #(.LANES(LANES)) u_edo_chk (
   .clk(clk), .rst_n(rst_n), .s_ras_n(s_ras_n), .s_cas_n(s_cas_n),
   .s_we_n(s_we_n), .s_oe_n(s_oe_n), .cas_fall(cas_fall), .we_fall(we_fall),
   .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid)
);

// File: tb/edo_dram_model_bench.sv
module edo_dram_model_bench;
   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1;
   logic [1:0]  cas_n = 2'b11;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic [9:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe, dq_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      int          req;
      logic [1:0]  oe;
      logic [1:0]  vld;
      logic [15:0] data;
   } exp_t;
   exp_t sb_q[$];
   event chk_ev;

   always #4 clk = ~clk;

   edo_dram_model #(.RD_LAT(LAT)) u_edo_dram_model (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe(dq_oe), .dq_valid(dq_valid)
   );

   // monitor: pops expected items and compares to the ports
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (dq_oe !== e.oe || dq_valid !== e.vld || dq_out !== e.data) begin
               failures++;
               $display("FAIL R%0d: oe=%b vld=%b data=%h, expected oe=%b vld=%b data=%h",
                        e.req, dq_oe, dq_valid, dq_out, e.oe, e.vld, e.data);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input int req, input logic [1:0] oe,
                             input logic [1:0] vld, input logic [15:0] data);
      exp_t e;
      e.req = req; e.oe = oe; e.vld = vld; e.data = data;
      sb_q.push_back(e);
      ->chk_ev;
      #1;
   endtask

   task automatic early_write(input logic [9:0] row, input logic [9:0] col,
                              input logic [15:0] data, input logic [1:0] lanes_n);
      ras_n = 1'b0; addr = row; tick(2);
      addr = col; we_n = 1'b0; dq_in = data; cas_n = lanes_n; tick(2);
      cas_n = 2'b11; we_n = 1'b1; tick(2);
      ras_n = 1'b1; tick(2);
   endtask

   task automatic close_row();
      cas_n = 2'b11; oe_n = 1'b1; we_n = 1'b1; tick(2);
      ras_n = 1'b1; tick(2);
   endtask

   initial begin
      tick(3);
      expect_out(9, 2'b00, 2'b00, 16'h0000);   // R9 reset state
      rst_n = 1'b1;
      tick(2);

      // R4: early write with oe_n low keeps lanes silent
      ras_n = 1'b0; addr = 10'd1; oe_n = 1'b0; tick(2);
      addr = 10'd2; we_n = 1'b0; dq_in = 16'hA1B2; cas_n = 2'b00; tick(LAT + 3);
      expect_out(4, 2'b00, 2'b00, 16'h0000);
      close_row();

      // R1/R10: read back, invalid then valid on the exact edge
      ras_n = 1'b0; addr = 10'd1; tick(2);
      addr = 10'd2; oe_n = 1'b0; cas_n = 2'b00; tick(1);
      addr = 10'd7;                             // R1: later address ignored
      tick(LAT);
      expect_out(10, 2'b11, 2'b00, 16'hA1B2);  // R10 edge LAT+1
      tick(1);
      expect_out(1, 2'b11, 2'b11, 16'hA1B2);   // R1 / R10 edge LAT+2
      // R7: EDO hold after strobe rise
      cas_n = 2'b11; tick(3);
      expect_out(7, 2'b11, 2'b11, 16'hA1B2);
      // R8: we_n fall between strobes
      we_n = 1'b0; tick(2);
      expect_out(8, 2'b00, 2'b00, 16'h0000);
      close_row();

      // R3: upper-lane-only early write
      early_write(10'd1, 10'd2, 16'h5C00, 2'b01);
      ras_n = 1'b0; addr = 10'd1; tick(2);
      addr = 10'd2; oe_n = 1'b0; cas_n = 2'b00; tick(LAT + 2);
      expect_out(3, 2'b11, 2'b11, 16'h5CB2);
      close_row();

      // R11: aliasing through high address bits
      ras_n = 1'b0; addr = 10'd9; tick(2);
      addr = 10'd10; oe_n = 1'b0; cas_n = 2'b00; tick(LAT + 2);
      expect_out(11, 2'b11, 2'b11, 16'h5CB2);
      close_row();

      // R5: delayed write captures data at the we_n fall
      ras_n = 1'b0; addr = 10'd3; tick(2);
      addr = 10'd5; cas_n = 2'b00; tick(2);
      dq_in = 16'h1234; we_n = 1'b0; tick(2);
      dq_in = 16'hFFFF; tick(2);
      close_row();
      ras_n = 1'b0; addr = 10'd3; tick(2);
      addr = 10'd5; oe_n = 1'b0; cas_n = 2'b00; tick(LAT + 2);
      expect_out(5, 2'b11, 2'b11, 16'h1234);
      close_row();

      // R2: second strobe reuses the latched column
      early_write(10'd2, 10'd1, 16'h1111, 2'b00);
      early_write(10'd2, 10'd6, 16'h6666, 2'b00);
      ras_n = 1'b0; addr = 10'd2; tick(2);
      addr = 10'd1; oe_n = 1'b0; cas_n = 2'b10; tick(2);
      addr = 10'd6; cas_n = 2'b00; tick(LAT + 2);
      expect_out(2, 2'b11, 2'b11, 16'h1111);
      cas_n = 2'b11; tick(2);
      cas_n = 2'b00; tick(LAT + 2);
      expect_out(2, 2'b11, 2'b11, 16'h6666);   // R2 new column after precharge
      // R6: oe_n high turns lanes off
      oe_n = 1'b1; tick(1);
      expect_out(6, 2'b00, 2'b00, 16'h0000);
      close_row();

      // R6: only the lower lane reads
      ras_n = 1'b0; addr = 10'd2; tick(2);
      addr = 10'd6; oe_n = 1'b0; cas_n = 2'b10; tick(LAT + 2);
      expect_out(6, 2'b01, 2'b01, 16'h0066);
      // R9: row strobe rise turns lanes off, lower strobe held low
      ras_n = 1'b1; tick(2);
      expect_out(9, 2'b00, 2'b00, 16'h0000);
      // R9: column latch re-armed by the row strobe rise
      ras_n = 1'b0; addr = 10'd2; tick(2);
      addr = 10'd6; cas_n = 2'b00; tick(LAT + 2);
      expect_out(9, 2'b10, 2'b10, 16'h6600);
      close_row();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule